// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

The router collects up to 64 device interrupt sources into one shared pending vector and fans them out to up to four processors. Each processor owns a private enable mask; its status word is the live bitwise AND of that mask with the shared pending vector. Each processor receives one level-sensitive interrupt line. The line is high while any bit of its status word is set, and it follows the status word after one register stage.

Devices drive two pulse inputs, each with a source index. The set pulse marks a source pending. The clear pulse withdraws a source. Software uses a small register port with 64-bit accesses. Registers sit on 64-byte boundaries, and the register index is the address shifted right by six. The port can write the masks and read the masks, the status words and the pending vector. The pending vector can also be read with a 32-bit access. Every other kind of access is refused with an error flag.

The register port is a two-state machine. In IDLE it is ready and takes a request; this is the ACCEPT transition into RESP. In RESP it presents the response for one cycle, then takes the RETIRE transition back to IDLE.

Top module: `irq_router`

## Requirements
- R1: After reset, every mask, every status word, the pending vector and every interrupt line are zero.
- R2: A read of processor c's status register returns that processor's mask ANDed with the pending vector, using the current value of both operands.
- R3: A set pulse for source n makes pending bit n one at the next clock edge.
- R4: Processor c's interrupt line equals the OR of all bits of its status word, delayed by exactly one clock.
- R5: A clear pulse for source n makes pending bit n zero. A clear pulse for a source that is not pending changes nothing.
- R6: When a set pulse and a clear pulse name the same source in the same cycle, the set wins and the bit ends up pending.
- R7: A mask write replaces the whole mask. An interrupt line rises after a write that enables a pending source, and falls after a write that removes the last enabled pending source.
- R8: Register index is address bits [ADDR_W-1:6]. The mask of processor c is at index c, the status of processor c is at index 4+c, and the pending vector is at index 8. Address bits [5:0] are ignored.
- R9: Size code 3 is a 64-bit access and size code 2 is a 32-bit access. A 32-bit read of the pending vector returns bits [31:0] in the low half and zeros in the high half.
- R10: The following accesses return the error flag with zero read data and change no register: size codes 0 and 1, any 32-bit access other than a read of the pending vector, any write to a status register or to the pending vector, and any unmapped index.
- R11: The port is ready only in IDLE. The response (valid, error flag, data) is presented for exactly one cycle, in the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set_valid | input | 1 | Set pulse for a device source |
| src_set_idx | input | 6 | Source index of the set pulse |
| src_clr_valid | input | 1 | Clear pulse for a device source |
| src_clr_idx | input | 6 | Source index of the clear pulse |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Port can take a request (IDLE) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | Access size code (3 = 64-bit, 2 = 32-bit) |
| req_addr | input | 12 | Byte offset within the register window |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response cycle (RESP) |
| resp_err | output | 1 | Access refused |
| resp_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Per-processor device interrupt line |

## Verification
A mask write taken by the port and a set or clear pulse from a device can land on the same clock edge. Both then change one operand of the status AND at once. The bench drives a set pulse for a source in the same cycle as the write that enables that source. It also drives a clear pulse in the same cycle as a write that enables the cleared source. The bench judges the result from the interrupt line one cycle later and from a status readback. The same-source set and clear collision is provoked the same way and is judged by a read of the pending vector.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int DATA_W        = 64;
    localparam int REG_SHIFT     = 6;
    localparam int IDX_MASK_BASE = 0;
    localparam int IDX_STAT_BASE = 4;
    localparam int IDX_PENDING   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic {
        PST_IDLE = 1'b0,
        PST_RESP = 1'b1
    } port_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MASK = 2'd1,
        TGT_STAT = 2'd2,
        TGT_PEND = 2'd3
    } target_e;

endpackage

// File: rtl/irq_pending_vec.sv
module irq_pending_vec
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [SRC_IDX_W-1:0] set_idx,
    input  logic                 clr_valid,
    input  logic [SRC_IDX_W-1:0] clr_idx,
    output logic [NUM_SRC-1:0]   pend_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] pend_d;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (set_valid && (set_idx == SRC_IDX_W'(n))) set_vec[n] = 1'b1;
            if (clr_valid && (clr_idx == SRC_IDX_W'(n))) clr_vec[n] = 1'b1;
        end
        // clearing a bit that is already zero leaves it zero; set has priority
        pend_d = (pend_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] status_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] mask_q;
    logic               irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign status_o = mask_q & pend;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_o;
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = ADDR_W - REG_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [1:0]                 req_size,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       resp_valid,
    output logic                       resp_err,
    output logic [DATA_W-1:0]          resp_rdata,
    input  logic [NUM_CPU*NUM_SRC-1:0] mask_flat,
    input  logic [NUM_CPU*NUM_SRC-1:0] status_flat,
    input  logic [NUM_SRC-1:0]         pend,
    output logic [NUM_CPU-1:0]         mask_we,
    output logic [NUM_SRC-1:0]         mask_wdata
);

    port_state_e         st_q, st_d;
    logic [IDX_W-1:0]    idx;
    target_e             tgt;
    logic [NUM_CPU-1:0]  mask_hit;
    logic [DATA_W-1:0]   rd_sel;
    acc_size_e           size;
    logic                size_ok;
    logic                refused;
    logic                accept;
    logic                err_q;
    logic [DATA_W-1:0]   rdata_q;

    assign idx  = req_addr[ADDR_W-1:REG_SHIFT];
    assign size = acc_size_e'(req_size);

    // register decode
    always_comb begin
        tgt      = TGT_NONE;
        mask_hit = '0;
        rd_sel   = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (idx == IDX_W'(IDX_MASK_BASE + c)) begin
                tgt         = TGT_MASK;
                mask_hit[c] = 1'b1;
                rd_sel      = DATA_W'(mask_flat[c*NUM_SRC +: NUM_SRC]);
            end else if (idx == IDX_W'(IDX_STAT_BASE + c)) begin
                tgt    = TGT_STAT;
                rd_sel = DATA_W'(status_flat[c*NUM_SRC +: NUM_SRC]);
            end
        end
        if (idx == IDX_W'(IDX_PENDING)) begin
            tgt    = TGT_PEND;
            rd_sel = DATA_W'(pend);
        end
    end

    always_comb begin
        unique case (size)
            SZ_DWORD: size_ok = 1'b1;
            SZ_WORD:  size_ok = (tgt == TGT_PEND) && !req_write;
            default:  size_ok = 1'b0;
        endcase
        refused = (tgt == TGT_NONE) || !size_ok || (req_write && (tgt != TGT_MASK));
    end

    assign accept     = (st_q == PST_IDLE) && req_valid;
    assign mask_we    = (accept && req_write && !refused) ? mask_hit : '0;
    assign mask_wdata = req_wdata[NUM_SRC-1:0];

    // next state: ACCEPT (IDLE->RESP), RETIRE (RESP->IDLE)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PST_IDLE: if (req_valid) st_d = PST_RESP;
            PST_RESP: st_d = PST_IDLE;
            default:  st_d = PST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PST_IDLE;
        else        st_q <= st_d;
    end

    // response outputs, captured on ACCEPT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            err_q <= refused;
            if (refused || req_write)  rdata_q <= '0;
            else if (size == SZ_WORD)  rdata_q <= {32'd0, rd_sel[31:0]};
            else                       rdata_q <= rd_sel;
        end
    end

    assign req_ready  = (st_q == PST_IDLE);
    assign resp_valid = (st_q == PST_RESP);
    assign resp_err   = (st_q == PST_RESP) && err_q;
    assign resp_rdata = (st_q == PST_RESP) ? rdata_q : '0;

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_set_valid,
    input  logic [SRC_IDX_W-1:0] src_set_idx,
    input  logic                 src_clr_valid,
    input  logic [SRC_IDX_W-1:0] src_clr_idx,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 resp_valid,
    output logic                 resp_err,
    output logic [DATA_W-1:0]    resp_rdata,
    output logic [NUM_CPU-1:0]   cpu_irq
);

    logic [NUM_SRC-1:0]         raw_q;
    logic [NUM_CPU*NUM_SRC-1:0] mask_flat;
    logic [NUM_CPU*NUM_SRC-1:0] status_flat;
    logic [NUM_CPU-1:0]         mask_we;
    logic [NUM_SRC-1:0]         mask_wdata;

    irq_pending_vec #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (src_set_valid),
        .set_idx   (src_set_idx),
        .clr_valid (src_clr_valid),
        .clr_idx   (src_clr_idx),
        .pend_o    (raw_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        irq_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we[c]),
            .mask_wdata (mask_wdata),
            .pend       (raw_q),
            .mask_o     (mask_flat[c*NUM_SRC +: NUM_SRC]),
            .status_o   (status_flat[c*NUM_SRC +: NUM_SRC]),
            .irq_o      (cpu_irq[c])
        );
    end

    irq_reg_port #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .ADDR_W  (ADDR_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .resp_valid  (resp_valid),
        .resp_err    (resp_err),
        .resp_rdata  (resp_rdata),
        .mask_flat   (mask_flat),
        .status_flat (status_flat),
        .pend        (raw_q),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    localparam int SRC_IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       src_set_valid,
    input logic [SRC_IDX_W-1:0]       src_set_idx,
    input logic                       src_clr_valid,
    input logic [SRC_IDX_W-1:0]       src_clr_idx,
    input logic                       req_ready,
    input logic                       resp_valid,
    input logic                       resp_err,
    input logic [NUM_SRC-1:0]         raw_q,
    input logic [NUM_CPU*NUM_SRC-1:0] mask_flat,
    input logic [NUM_CPU-1:0]         cpu_irq
);

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        src_set_valid |=> raw_q[$past(src_set_idx)]); // R3

    AST_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr_valid && !src_set_valid && !raw_q[src_clr_idx]) |=> $stable(raw_q)); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set_valid && src_clr_valid && (src_set_idx == src_clr_idx))
        |=> raw_q[$past(src_clr_idx)]); // R6

    AST_REFUSED_KEEPS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (mask_flat == $past(mask_flat))); // R10

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R11

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready); // R11

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] == (|($past(mask_flat[c*NUM_SRC +: NUM_SRC] & raw_q)))); // R4
    end

endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_set_valid (src_set_valid),
    .src_set_idx   (src_set_idx),
    .src_clr_valid (src_clr_valid),
    .src_clr_idx   (src_clr_idx),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_err      (resp_err),
    .raw_q         (raw_q),
    .mask_flat     (mask_flat),
    .cpu_irq       (cpu_irq)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int NS = 64;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_set_valid = 1'b0;
    logic [5:0]  src_set_idx = '0;
    logic        src_clr_valid = 1'b0;
    logic [5:0]  src_clr_idx = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd3;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [63:0] resp_rdata;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_mask [NC];
    logic [63:0] m_pend;

    always #5 clk = ~clk;

    irq_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_set_valid(src_set_valid), .src_set_idx(src_set_idx),
        .src_clr_valid(src_clr_valid), .src_clr_idx(src_clr_idx),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int c = 0; c < NC; c++) r[c] = |(m_mask[c] & m_pend);
        return r;
    endfunction

    // one register access; returns at the negedge after RETIRE
    task automatic access(input bit wr, input logic [1:0] sz, input int idx,
                          input logic [63:0] wd, input logic [5:0] low,
                          output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = {idx[5:0], low}; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid === 1'b1, "R11 resp_valid", {63'd0, resp_valid}, 64'd1);
        chk(req_ready === 1'b0, "R11 ready low in RESP", {63'd0, req_ready}, 64'd0);
        rd = resp_rdata; er = resp_err;
        @(negedge clk);
        chk(resp_valid === 1'b0, "R11 single response", {63'd0, resp_valid}, 64'd0);
    endtask

    task automatic pulse(input bit sv, input int si, input bit cv, input int ci);
        @(negedge clk);
        src_set_valid = sv; src_set_idx = si[5:0];
        src_clr_valid = cv; src_clr_idx = ci[5:0];
        @(negedge clk);
        src_set_valid = 1'b0; src_clr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_pend_chk(input string req);
        logic [63:0] rd; logic er;
        access(1'b0, 2'd3, 8, '0, 6'd0, rd, er);
        chk(rd === m_pend && !er, req, rd, m_pend);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] rd;
        logic er;
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        m_pend = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cpu_irq === 4'd0, "R1 irq after reset", {60'd0, cpu_irq}, 64'd0);
        chk(req_ready === 1'b1, "R11 ready in IDLE", {63'd0, req_ready}, 64'd1);
        for (int i = 0; i < 9; i++) begin
            access(1'b0, 2'd3, i, '0, 6'd0, rd, er);
            chk(rd === 64'd0 && !er, "R1 register zero after reset", rd, 64'd0);
        end

        // R7/R8 mask writes and readback; address low bits ignored
        for (int c = 0; c < NC; c++) begin
            logic [63:0] v;
            for (int b = 0; b < NS; b++) v[b] = ((b + c) % (c + 2)) == 0;
            access(1'b1, 2'd3, c, v, 6'(c * 8 + 7), rd, er);
            chk(!er, "R7 mask write accepted", {63'd0, er}, 64'd0);
            m_mask[c] = v;
        end
        for (int c = 0; c < NC; c++) begin
            access(1'b0, 2'd3, c, '0, 6'd0, rd, er);
            chk(rd === m_mask[c], "R8 mask readback", rd, m_mask[c]);
        end

        // R3/R4/R2/R5 sweep over every source
        for (int s = 0; s < NS; s++) begin
            pulse(1'b1, s, 1'b0, 0);
            m_pend[s] = 1'b1;
            chk(cpu_irq === exp_irq(), "R4 irq after set (R3)", {60'd0, cpu_irq}, {60'd0, exp_irq()});
            for (int c = 0; c < NC; c++) begin
                access(1'b0, 2'd3, 4 + c, '0, 6'd0, rd, er);
                chk(rd === (m_mask[c] & m_pend), "R2 status readback", rd, m_mask[c] & m_pend);
            end
            read_pend_chk("R3 pending after set");
            pulse(1'b0, 0, 1'b1, s);
            m_pend[s] = 1'b0;
            chk(cpu_irq === 4'd0, "R5 irq after clear", {60'd0, cpu_irq}, 64'd0);
        end

        // R5 spurious clear leaves other bits
        pulse(1'b1, 10, 1'b0, 0); m_pend[10] = 1'b1;
        pulse(1'b1, 41, 1'b0, 0); m_pend[41] = 1'b1;
        pulse(1'b0, 0, 1'b1, 11);
        read_pend_chk("R5 spurious clear no change");
        chk(cpu_irq === exp_irq(), "R5 irq unchanged after spurious clear", {60'd0, cpu_irq}, {60'd0, exp_irq()});

        // R6 set and clear same source same cycle
        pulse(1'b1, 20, 1'b1, 20); m_pend[20] = 1'b1;
        read_pend_chk("R6 set beats clear");
        // set one source, clear another in same cycle
        pulse(1'b1, 33, 1'b1, 10); m_pend[33] = 1'b1; m_pend[10] = 1'b0;
        read_pend_chk("R6 independent set and clear");

        // R7 mask enabling/disabling pending sources
        access(1'b1, 2'd3, 2, 64'd1 << 41, 6'd0, rd, er); m_mask[2] = 64'd1 << 41;
        chk(cpu_irq[2] === 1'b1, "R7 irq rises on enable", {63'd0, cpu_irq[2]}, 64'd1);
        access(1'b1, 2'd3, 2, 64'd1 << 40, 6'd0, rd, er); m_mask[2] = 64'd1 << 40;
        chk(cpu_irq[2] === 1'b0, "R7 irq falls on disable", {63'd0, cpu_irq[2]}, 64'd0);

        // same-cycle mask write and set pulse (R7 with R3)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3;
        req_addr = {6'd0, 6'd0}; req_wdata = 64'd1 << 5;
        src_set_valid = 1'b1; src_set_idx = 6'd5;
        @(negedge clk);
        req_valid = 1'b0; src_set_valid = 1'b0;
        m_mask[0] = 64'd1 << 5; m_pend[5] = 1'b1;
        chk(resp_valid === 1'b1 && resp_err === 1'b0, "R7 concurrent write response", {63'd0, resp_err}, 64'd0);
        @(negedge clk);
        chk(cpu_irq === exp_irq(), "R7 irq after concurrent write and set", {60'd0, cpu_irq}, {60'd0, exp_irq()});
        access(1'b0, 2'd3, 4, '0, 6'd0, rd, er);
        chk(rd === (m_mask[0] & m_pend), "R2 status after concurrent update", rd, m_mask[0] & m_pend);

        // same-cycle mask write enabling a source and clear of it
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3;
        req_addr = {6'd1, 6'd0}; req_wdata = 64'd1 << 33;
        src_clr_valid = 1'b1; src_clr_idx = 6'd33;
        @(negedge clk);
        req_valid = 1'b0; src_clr_valid = 1'b0;
        m_mask[1] = 64'd1 << 33; m_pend[33] = 1'b0;
        @(negedge clk);
        chk(cpu_irq[1] === 1'b0, "R7 no irq when enabled source cleared same cycle", {63'd0, cpu_irq[1]}, 64'd0);

        // R9 32-bit read of pending vector
        pulse(1'b1, 63, 1'b0, 0); m_pend[63] = 1'b1;
        access(1'b0, 2'd2, 8, '0, 6'd0, rd, er);
        chk(rd === {32'd0, m_pend[31:0]} && !er, "R9 32-bit pending read", rd, {32'd0, m_pend[31:0]});
        access(1'b0, 2'd3, 8, '0, 6'd0, rd, er);
        chk(rd === m_pend, "R9 64-bit pending read", rd, m_pend);

        // R10 refused accesses
        for (int sz = 0; sz < 3; sz++) begin
            access(1'b1, 2'(sz), 0, 64'hFFFF, 6'd0, rd, er);
            chk(er === 1'b1, "R10 bad size write refused", {63'd0, er}, 64'd1);
            access(1'b0, 2'(sz), 0, '0, 6'd0, rd, er);
            chk(er === 1'b1 && rd === 64'd0, "R10 bad size read refused", rd, 64'd0);
        end
        for (int i = 4; i < 9; i++) begin
            access(1'b1, 2'd3, i, '1, 6'd0, rd, er);
            chk(er === 1'b1, "R10 write to read-only refused", {63'd0, er}, 64'd1);
        end
        for (int i = 9; i < 64; i += 9) begin
            access(1'b0, 2'd3, i, '0, 6'd0, rd, er);
            chk(er === 1'b1 && rd === 64'd0, "R10 unmapped index", rd, 64'd0);
        end
        access(1'b0, 2'd2, 4, '0, 6'd0, rd, er);
        chk(er === 1'b1, "R10 32-bit status read refused", {63'd0, er}, 64'd1);
        read_pend_chk("R10 pending untouched by refused writes");
        for (int c = 0; c < NC; c++) begin
            access(1'b0, 2'd3, c, '0, 6'd0, rd, er);
            chk(rd === m_mask[c], "R10 masks untouched by refused writes", rd, m_mask[c]);
        end
        chk(cpu_irq === exp_irq(), "R4 irq final", {60'd0, cpu_irq}, {60'd0, exp_irq()});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule